// File: doc/BRIEF.md
# Colour Lookup Table Memory

This block holds the colour lookup table of a display controller. A processor-side port sees it as 128 words of 32 bits in a 512-byte window of the register space, from byte offset 0x200 through 0x3FF. Every word packs two 16-bit colour entries, so the table holds 256 colours in all. Bus writes store the full word as given. Bus reads return exactly what was stored, including bits that play no part in the displayed colour.

A second, independent port serves the pixel pipeline. It takes an 8-bit pixel index and returns a 24-bit colour one clock later. Each 5-bit component is widened to 8 bits by appending three zero bits. The storage is plain synchronous memory without reset, so a block RAM can be inferred. The output registers that follow it are cleared by the synchronous reset.

Top module: `pal_ram_top`

## Requirements
- R1: A bus write to an in-window offset stores all 32 bits. A later bus read of the same word returns them unchanged, including bits 15 and 31. Read data appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`.
- R2: The word an access reaches is (offset − 0x200) >> 2. Byte-offset bits [1:0] do not change which word is reached.
- R3: An access with an offset below 0x200 or above 0x3FF is ignored. Such a write changes no stored word, and such a read returns zero. `bus_rdata` is zero in every cycle that does not follow an in-window read.
- R4: Pixel index bits [7:1] pick the word. Index bit 0 picks the halfword: 0 selects bits [15:0] and 1 selects bits [31:16].
- R5: Within a 16-bit entry, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. `pix_rgb` carries red in [23:16], green in [15:8] and blue in [7:0].
- R6: Each output component equals its 5-bit field shifted left by three, so bits [2:0], [10:8] and [18:16] of `pix_rgb` are always zero.
- R7: Entry bit 15 (the intensity bit) has no effect on the colour returned by a lookup.
- R8: A lookup has one cycle of latency. `pix_rgb` changes only after the clock edge that samples a new `pix_idx`.
- R9: When a write and a lookup (or a bus read) reach the same word at the same edge, the old contents are returned. The new contents are visible from the next edge on.
- R10: While `rst` is high at a clock edge, both `bus_rdata` and `pix_rgb` are zero after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | 12 | Bus byte offset |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Bus read data, registered |
| pix_idx | input | 8 | Pixel colour index |
| pix_rgb | output | 24 | Expanded colour {red, green, blue}, 8 bits each |

## Verification
Every word is written and read back, and all 256 indices are looked up, under two hashed patterns. The second pattern differs from the first only in the intensity bits. Matching readback under the first pattern separates correct word indexing from aliasing. The second pattern tells raw storage (the readback changes) apart from colour expansion (the lookup does not). Single-component words catch swapped channel fields or halfword order. Offsets just outside the window, low-order offset bits, a changed index sampled before and after its edge, and a write colliding with a lookup of the same word cover the decode, the latency and the read-before-write ordering.

// File: rtl/pal_pkg.sv
package pal_pkg;
  // defaults shared by the table and its checker
  localparam int PAL_WORDS    = 128;
  localparam int PAL_DATA_W   = 32;
  localparam int PAL_COMP_W   = 5;
  localparam int PAL_OUT_W    = 8;
  localparam int PAL_ADDR_W   = 12;
  localparam int PAL_BASE_OFF = 'h200;
  localparam int PAL_NCOMP    = 3;
endpackage

// File: rtl/pal_word_ram.sv
module pal_word_ram #(
  parameter int WORDS  = 128,
  parameter int DATA_W = 32,
  parameter int AW     = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              a_en,
  input  logic [AW-1:0]     a_addr,
  output logic [DATA_W-1:0] a_data,
  input  logic [AW-1:0]     b_addr,
  output logic [DATA_W-1:0] b_data
);
  logic [DATA_W-1:0] mem [WORDS];

  // read-before-write on both read ports
  always_ff @(posedge clk) begin
    if (we)   mem[waddr] <= wdata;
    if (a_en) a_data <= mem[a_addr];
    b_data <= mem[b_addr];
  end
endmodule

// File: rtl/pal_expand.sv
module pal_expand #(
  parameter int COMP_W = 5,
  parameter int OUT_W  = 8,
  parameter int NCOMP  = 3,
  localparam int IN_W  = COMP_W * NCOMP,
  localparam int RGB_W = OUT_W * NCOMP
) (
  input  logic [IN_W-1:0]  fields,
  output logic [RGB_W-1:0] rgb
);
  // field 0 (red) lands in the top byte, last field in the bottom byte
  for (genvar c = 0; c < NCOMP; c++) begin : g_comp
    assign rgb[(NCOMP-1-c)*OUT_W +: OUT_W] =
      {fields[c*COMP_W +: COMP_W], {(OUT_W-COMP_W){1'b0}}};
  end
endmodule

// File: rtl/pal_ram_top.sv
module pal_ram_top
  import pal_pkg::*;
#(
  parameter int WORDS    = PAL_WORDS,
  parameter int DATA_W   = PAL_DATA_W,
  parameter int COMP_W   = PAL_COMP_W,
  parameter int OUT_W    = PAL_OUT_W,
  parameter int ADDR_W   = PAL_ADDR_W,
  parameter int BASE_OFF = PAL_BASE_OFF,
  localparam int WIDX_W  = $clog2(WORDS),
  localparam int IDX_W   = WIDX_W + 1,
  localparam int RGB_W   = OUT_W * PAL_NCOMP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic [RGB_W-1:0]  pix_rgb
);
  localparam int ENTRY_W = DATA_W / 2;
  localparam int FLD_W   = COMP_W * PAL_NCOMP;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_OFF);
  localparam logic [ADDR_W-1:0] END_A  = ADDR_W'(BASE_OFF + WORDS * 4);

  logic              in_win, wr_go, rd_go;
  logic [WIDX_W-1:0] bus_widx;
  logic [DATA_W-1:0] a_data, b_data;
  logic              rd_hit_q, half_q, live_q;
  logic [FLD_W-1:0]  sel_fields;
  logic [RGB_W-1:0]  rgb_raw;
  logic              unused_ibits;

  assign in_win   = (bus_addr >= BASE_A) && (bus_addr < END_A);
  assign bus_widx = WIDX_W'((bus_addr - BASE_A) >> 2);
  assign wr_go    = bus_wr && in_win;
  assign rd_go    = bus_rd && in_win;

  pal_word_ram #(
    .WORDS  (WORDS),
    .DATA_W (DATA_W),
    .AW     (WIDX_W)
  ) ram_i (
    .clk    (clk),
    .we     (wr_go),
    .waddr  (bus_widx),
    .wdata  (bus_wdata),
    .a_en   (rd_go),
    .a_addr (bus_widx),
    .a_data (a_data),
    .b_addr (pix_idx[IDX_W-1:1]),
    .b_data (b_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_hit_q <= 1'b0;
      half_q   <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      rd_hit_q <= rd_go;
      half_q   <= pix_idx[0];
      live_q   <= 1'b1;
    end
  end

  // halfword pick; the intensity bit of each entry is never displayed
  assign sel_fields   = half_q ? b_data[ENTRY_W +: FLD_W] : b_data[0 +: FLD_W];
  assign unused_ibits = ^{b_data[DATA_W-1], b_data[ENTRY_W-1]};

  pal_expand #(
    .COMP_W (COMP_W),
    .OUT_W  (OUT_W),
    .NCOMP  (PAL_NCOMP)
  ) exp_i (
    .fields (sel_fields),
    .rgb    (rgb_raw)
  );

  assign pix_rgb   = live_q   ? rgb_raw : '0;
  assign bus_rdata = rd_hit_q ? a_data  : '0;
endmodule

// File: rtl/pal_ram_chk.sv
module pal_ram_chk
  import pal_pkg::*;
#(
  parameter int WORDS    = PAL_WORDS,
  parameter int DATA_W   = PAL_DATA_W,
  parameter int COMP_W   = PAL_COMP_W,
  parameter int OUT_W    = PAL_OUT_W,
  parameter int ADDR_W   = PAL_ADDR_W,
  parameter int BASE_OFF = PAL_BASE_OFF,
  localparam int WIDX_W  = $clog2(WORDS),
  localparam int IDX_W   = WIDX_W + 1,
  localparam int RGB_W   = OUT_W * PAL_NCOMP
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [IDX_W-1:0]  pix_idx,
  input logic [RGB_W-1:0]  pix_rgb
);
  localparam int ENTRY_W = DATA_W / 2;

  function automatic logic win(input logic [ADDR_W-1:0] a);
    return (int'(a) >= BASE_OFF) && (int'(a) < BASE_OFF + WORDS * 4);
  endfunction

  function automatic logic [WIDX_W-1:0] widx(input logic [ADDR_W-1:0] a);
    return WIDX_W'((int'(a) - BASE_OFF) >> 2);
  endfunction

  function automatic logic [RGB_W-1:0] xp(input logic [DATA_W-1:0] w, input logic h);
    logic [ENTRY_W-1:0] e;
    logic [RGB_W-1:0] r;
    e = h ? w[DATA_W-1:ENTRY_W] : w[ENTRY_W-1:0];
    r = '0;
    for (int c = 0; c < PAL_NCOMP; c++)
      r[(PAL_NCOMP-1-c)*OUT_W +: OUT_W] = {e[c*COMP_W +: COMP_W], {(OUT_W-COMP_W){1'b0}}};
    return r;
  endfunction

  function automatic logic [RGB_W-1:0] low_mask();
    logic [RGB_W-1:0] m;
    m = '0;
    for (int c = 0; c < PAL_NCOMP; c++)
      m[c*OUT_W +: (OUT_W-COMP_W)] = '1;
    return m;
  endfunction

  // last in-window write, kept as an independent reference
  logic              rec_valid;
  logic [WIDX_W-1:0] rec_idx;
  logic [DATA_W-1:0] rec_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rec_valid <= 1'b0;
      rec_idx   <= '0;
      rec_data  <= '0;
    end else if (bus_wr && win(bus_addr)) begin
      rec_valid <= 1'b1;
      rec_idx   <= widx(bus_addr);
      rec_data  <= bus_wdata;
    end
  end

  assert_readback_R1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && win(bus_addr) && rec_valid && widx(bus_addr) == rec_idx)
    |=> (bus_rdata == $past(rec_data)));

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && win(bus_addr)) |=> (bus_rdata == '0));

  // lookup of the recorded word one edge later: covers R4, R5, R8, R9
  assert_lookup_R8: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && pix_idx[IDX_W-1:1] == rec_idx)
    |=> (pix_rgb == xp($past(rec_data), $past(pix_idx[0]))));

  assert_low_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ((pix_rgb & low_mask()) == '0));

  assert_reset_out_R10: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && pix_rgb == '0));
endmodule

bind pal_ram_top pal_ram_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pix_idx   (pix_idx),
  .pix_rgb   (pix_rgb)
);

// File: tb/pal_ram_top_tb_top.sv
module pal_ram_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pix_idx = '0;
  logic [23:0] pix_rgb;

  int total = 0, bad = 0;
  logic [31:0] mdl [128];

  always #4 clk = ~clk;

  pal_ram_top dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pix_idx(pix_idx), .pix_rgb(pix_rgb)
  );

  function automatic logic [31:0] pat(input int n, input int s);
    return 32'(n) * 32'h9E3779B1 + 32'(s) * 32'h7F4A7C15;
  endfunction

  // red = bits 4:0, green = 9:5, blue = 14:10, each times 8
  function automatic logic [23:0] exp_rgb(input logic [31:0] w, input logic h);
    int e, r, g, b;
    e = h ? int'(w >> 16) & 'hFFFF : int'(w) & 'hFFFF;
    r = (e & 31) * 8;
    g = ((e >> 5) & 31) * 8;
    b = ((e >> 10) & 31) * 8;
    return 24'(r * 65536 + g * 256 + b);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 12'(addr); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 12'(addr);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic look(input int idx, output logic [23:0] c);
    @(negedge clk);
    pix_idx = 8'(idx);
    @(negedge clk);
    c = pix_rgb;
  endtask

  task automatic sweep(input string req);
    logic [31:0] d;
    logic [23:0] c;
    for (int n = 0; n < 128; n++) begin
      rd('h200 + 4 * n, d);
      chk({req, " R1 readback"}, d, mdl[n]);
    end
    for (int i = 0; i < 256; i++) begin
      look(i, c);
      chk({req, " R4 R5 R6 lookup"}, 32'(c), 32'(exp_rgb(mdl[i/2], i[0])));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [23:0] c;
    repeat (3) @(negedge clk);
    // R10: outputs held at zero during reset
    chk("R10 rdata in reset", bus_rdata, 32'h0);
    chk("R10 rgb in reset", 32'(pix_rgb), 32'h0);
    @(negedge clk); rst = 1'b0;

    // pattern A: hashed words
    for (int n = 0; n < 128; n++) begin
      mdl[n] = pat(n, 1);
      wr('h200 + 4 * n, mdl[n]);
    end
    sweep("patA");

    // R5: single-component words
    wr('h200 + 4 * 5, 32'h0000_001F);
    look(10, c); chk("R5 red only", 32'(c), 32'hF8_0000);
    wr('h200 + 4 * 5, 32'h03E0_0000);
    look(11, c); chk("R5 green only half1", 32'(c), 32'h00_F800);
    look(10, c); chk("R4 half0 zero", 32'(c), 32'h0);
    wr('h200 + 4 * 6, 32'h0000_7C00);
    look(12, c); chk("R5 blue only", 32'(c), 32'h00_00F8);
    look(12, c); chk("R6 low bits zero", 32'(c) & 32'h07_0707, 32'h0);
    mdl[5] = 32'h03E0_0000; mdl[6] = 32'h0000_7C00;

    // R7: flip only the intensity bits; raw view changes, colours do not
    for (int n = 0; n < 128; n++) begin
      mdl[n] = mdl[n] ^ 32'h8000_8000;
      wr('h200 + 4 * n, mdl[n]);
    end
    sweep("R7 intensity");

    // R2: low offset bits do not change the word
    wr('h200 + 4 * 9 + 3, 32'h1234_5678); mdl[9] = 32'h1234_5678;
    rd('h200 + 4 * 9 + 1, d); chk("R2 low bits", d, 32'h1234_5678);
    rd('h200 + 4 * 8, d); chk("R2 neighbour intact", d, mdl[8]);
    look(18, c); chk("R2 lookup same word", 32'(c), 32'(exp_rgb(32'h1234_5678, 1'b0)));

    // R3: outside the window
    wr('h1FC, 32'hDEAD_BEEF); wr('h400, 32'hCAFE_F00D);
    wr('h000, 32'h5555_5555); wr('hFFC, 32'hAAAA_AAAA);
    rd('h1FC, d); chk("R3 read below", d, 32'h0);
    rd('h400, d); chk("R3 read above", d, 32'h0);
    rd('h200, d); chk("R3 word0 intact", d, mdl[0]);
    rd('h3FC, d); chk("R3 word127 intact", d, mdl[127]);
    look(255, c); chk("R3 lookup 255 intact", 32'(c), 32'(exp_rgb(mdl[127], 1'b1)));

    // R8: one cycle latency
    wr('h200 + 4 * 20, 32'h0000_7FFF); mdl[20] = 32'h0000_7FFF;
    wr('h200 + 4 * 21, 32'h0000_0421); mdl[21] = 32'h0000_0421;
    look(40, c); chk("R8 first", 32'(c), 32'hF8_F8F8);
    @(negedge clk); pix_idx = 8'd42;
    #1 chk("R8 before edge", 32'(pix_rgb), 32'hF8_F8F8);
    @(negedge clk); chk("R8 after edge", 32'(pix_rgb), 32'h08_0808);

    // R9: same-edge write with lookup and bus read of that word
    wr('h200 + 4 * 30, 32'h0000_001F); mdl[30] = 32'h0000_001F;
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'('h200 + 4 * 30);
    bus_wdata = 32'h0000_03E0; pix_idx = 8'd60;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    chk("R9 lookup old", 32'(pix_rgb), 32'hF8_0000);
    chk("R9 bus read old", bus_rdata, 32'h0000_001F);
    @(negedge clk);
    chk("R9 lookup new", 32'(pix_rgb), 32'h00_F800);
    chk("R3 rdata idle zero", bus_rdata, 32'h0);

    // R10: reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R10 rgb after reset", 32'(pix_rgb), 32'h0);
    chk("R10 rdata after reset", bus_rdata, 32'h0);
    rst = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule